// File: doc/BRIEF.md
# Random-Bit Source Statistical Health Tester

This block checks the statistical quality of a random-bit stream over fixed blocks of 20,000 bits. It runs three tests in parallel: a count of ones (monobit), a count of how often each 4-bit value appears (poker), and a count of runs of equal bits by length and bit value (runs). Every counter restarts at the start of each block. The pass or fail decision is made once, at the end of the block.

Software drives the tester through a small word-addressed register bus. In test mode it writes known data through two 32-bit raw-data registers, 64 bits per step, and follows a ready bit in the status word. This lets a known-answer check run before the source is trusted. A stall bit freezes the counters at the end of a block so their final values can be read. A live-sample mode copies the source's current bits into the raw registers so software can see that the source is not stuck at zero.

Registers, by word address: 0 control (bit 8 test mode), 1 test (bit 5 known-data injection, bit 13 live sample), 2 status, 3 flag acknowledge, 4 alarm (bit 15 stall), 5 raw low, 6 raw high, 7 ones count, 8 to 11 poker counts.

Top module: `ent_hlth_top`

## Requirements
- R1: After reset every register reads zero, so the status ready bit (bit 8) is low.
- R2: Status bit 8 reads 1 in the cycle after both control bit 8 and test bit 5 are set, with no fail flag set. A write that changes whether both bits are set clears all test counters and fail flags.
- R3: A write to raw high (address 6) while ready is 1 starts a 64-bit step: the 32 bits of raw low, least significant bit first, then the 32 written bits, least significant bit first. Ready reads 0 until every bit of the step has been counted, then reads 1 again.
- R4: When 19,968 bits of the block have been counted, a write to raw low alone starts a 32-bit step made of the written value. At any other count, a raw-low write starts no step. Data writes while ready is 0 are ignored.
- R5: Address 7 reads the number of ones counted in the current block.
- R6: Each group of 4 bits, aligned to the block start, forms a value whose first bit is its least significant bit. The count for value v reads as bits [8*(v mod 4)+7 : 8*(v mod 4)] of address 8 + v/4, as the low 8 bits of the count.
- R7: At block end, status bit 7 is set unless the ones count N satisfies 9654 < N < 10346.
- R8: At block end, status bit 6 is set unless 25,005,150 < 16·S < 25,287,000, where S is the sum over the 16 values of the squared full counts.
- R9: At block end, status bit 4 is set if, for either bit value, the number of runs of length 1, 2, 3, 4, 5 or 6-and-over falls outside [2267,2733], [1079,1421], [502,748], [223,402], [90,223] or [90,223] respectively. A run still open at block end is counted.
- R10: Fail flags are set only at block end and stay set. Writing 1 to bit 7, 6 or 4 of address 3 clears the matching flag and leaves the others.
- R11: With alarm bit 15 set, the counters keep their end-of-block values. Steps fed after that are consumed but not counted. Clearing bit 15 zeroes the counters.
- R12: With alarm bit 15 clear, the counters return to zero as soon as a block has been evaluated.
- R13: Clearing test bit 5 drops ready and clears the counters and fail flags.
- R14: While test bit 13 is set, raw low and raw high read the low and high halves of `noise_in`, sampled every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe; data taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| noise_in | input | 64 | Current bits from the random source |

## Verification
The assertions assume that software writes one register per cycle and waits for ready before it supplies the next data. They also assume that the final 32 bits of a block go in as a lone raw-low write, and that the stall bit is not changed while a block is being evaluated. The stimulus acts as such a driver: it polls the status word after every step, builds each block as 312 full steps plus one low-only step, and makes its one ignored-write probe while ready is low. Known, seeded-random and all-ones blocks then drive each test to pass or fail in turn.

// File: rtl/ent_hlth_pkg.sv
// Shared constants for the health tester: register addresses, bit positions
// and the acceptance thresholds. Assumes 20,000-bit blocks.
package ent_hlth_pkg;
    localparam logic [3:0] RG_CTRL  = 4'd0;
    localparam logic [3:0] RG_TEST  = 4'd1;
    localparam logic [3:0] RG_STAT  = 4'd2;
    localparam logic [3:0] RG_ACK   = 4'd3;
    localparam logic [3:0] RG_ALARM = 4'd4;
    localparam logic [3:0] RG_RAWLO = 4'd5;
    localparam logic [3:0] RG_RAWHI = 4'd6;
    localparam logic [3:0] RG_ONES  = 4'd7;
    localparam logic [3:0] RG_PK0   = 4'd8;
    localparam logic [3:0] RG_PK1   = 4'd9;
    localparam logic [3:0] RG_PK2   = 4'd10;
    localparam logic [3:0] RG_PK3   = 4'd11;

    localparam int B_TMODE = 8;
    localparam int B_KNOWN = 5;
    localparam int B_LIVE  = 13;
    localparam int B_READY = 8;
    localparam int B_FMONO = 7;
    localparam int B_FPOK  = 6;
    localparam int B_FRUN  = 4;
    localparam int B_STALL = 15;

    localparam int MONO_LO = 9654;
    localparam int MONO_HI = 10346;
    localparam longint POK_LO = 64'd25005150;
    localparam longint POK_HI = 64'd25287000;

    // Lowest accepted run count for run length class k (k = 5 means 6 and over).
    function automatic int run_min(input int k);
        case (k)
            0: return 2267;
            1: return 1079;
            2: return 502;
            3: return 223;
            default: return 90;
        endcase
    endfunction

    // Highest accepted run count for run length class k.
    function automatic int run_max(input int k);
        case (k)
            0: return 2733;
            1: return 1421;
            2: return 748;
            3: return 402;
            default: return 223;
        endcase
    endfunction
endpackage

// File: rtl/ent_hlth_ser.sv
// Step serializer: takes one 64-bit (or 32-bit) step and presents it one bit
// per cycle, least significant bit first. Assumes start only while idle.
module ent_hlth_ser #(
    parameter int DW = 32,
    localparam int NW = 2 * DW,
    localparam int CNW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic          half,
    input  logic [NW-1:0] data,
    output logic          bit_vld,
    output logic          bit_val,
    output logic          busy
);
    logic [NW-1:0]  shreg;
    logic [CNW-1:0] left;

    // Load a step, then shift one bit out per cycle until none remain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            left  <= '0;
        end else if (start) begin
            shreg <= data;
            left  <= half ? CNW'(DW) : CNW'(NW);
        end else if (left != '0) begin
            shreg <= shreg >> 1;
            left  <= left - CNW'(1);
        end
    end

    assign bit_vld = (left != '0);
    assign bit_val = shreg[0];
    assign busy    = bit_vld;
endmodule

// File: rtl/ent_hlth_stats.sv
// Bit-serial statistics: ones, 4-bit value and run-length counters over one
// block, judged against the thresholds in the cycle after the last bit.
// Assumes bits arrive only while busy is low; thresholds assume 20,000 bits.
module ent_hlth_stats
    import ent_hlth_pkg::*;
#(
    parameter int BLOCK_BITS = 20000,
    localparam int CW = $clog2(BLOCK_BITS + 1),
    localparam int SW = 2 * CW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          stall,
    input  logic          bit_vld,
    input  logic          bit_val,
    output logic [CW-1:0] ones_cnt,
    output logic [CW-1:0] pk_cnt [16],
    output logic          eval_o,
    output logic          mono_fail,
    output logic          poker_fail,
    output logic          runs_fail,
    output logic          busy,
    output logic          held,
    output logic          last_half
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] idx;
    logic          eval_pend;
    logic          prev_bit;
    logic [2:0]    run_len, len_nx, len_same, same_m1, prev_m1;
    logic [2:0]    nib_sr;
    logic [CW-1:0] run_cnt [2][6];
    logic [5:0]    run_inc [2];
    logic          take, first, last, clr_cnt;
    logic [SW-1:0] sumsq, sq_t;

    assign take     = bit_vld && !held && !eval_pend;
    assign first    = (idx == '0);
    assign last     = (idx == CW'(BLOCK_BITS - 1));
    assign clr_cnt  = clr || (eval_pend && !stall) || (held && !stall);
    assign len_same = (run_len == 3'd6) ? 3'd6 : run_len + 3'd1;
    assign same_m1  = len_same - 3'd1;
    assign prev_m1  = run_len - 3'd1;

    // Decide which run counters close on this bit and the next run length.
    always_comb begin
        run_inc[0] = '0;
        run_inc[1] = '0;
        len_nx     = run_len;
        if (take) begin
            if (first) begin
                len_nx = 3'd1;
            end else if (bit_val == prev_bit) begin
                len_nx = len_same;
                if (last) run_inc[bit_val][same_m1] = 1'b1;
            end else begin
                run_inc[prev_bit][prev_m1] = 1'b1;
                len_nx = 3'd1;
                if (last) run_inc[bit_val][0] = 1'b1;
            end
        end
    end

    // Track block position, run state, nibble assembly, evaluation and hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx       <= '0;
            eval_pend <= 1'b0;
            held      <= 1'b0;
            prev_bit  <= 1'b0;
            run_len   <= '0;
            nib_sr    <= '0;
        end else begin
            if (take) begin
                idx       <= last ? '0 : idx + ONE;
                eval_pend <= last;
                prev_bit  <= bit_val;
                run_len   <= len_nx;
                nib_sr    <= {bit_val, nib_sr[2:1]};
            end
            if (eval_pend) begin
                eval_pend <= 1'b0;
                held      <= stall;
            end
            if (held && !stall) held <= 1'b0;
        end
    end

    // Accumulate ones, 4-bit value counts and closed runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cnt) begin
            ones_cnt <= '0;
            for (int v = 0; v < 16; v++) pk_cnt[v] <= '0;
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 6; k++) run_cnt[b][k] <= '0;
        end else if (take) begin
            ones_cnt <= ones_cnt + CW'(bit_val);
            if (idx[1:0] == 2'd3) pk_cnt[{bit_val, nib_sr}] <= pk_cnt[{bit_val, nib_sr}] + ONE;
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 6; k++)
                    run_cnt[b][k] <= run_cnt[b][k] + CW'(run_inc[b][k]);
        end
    end

    // Judge the finished block against the acceptance windows.
    always_comb begin
        sumsq = '0;
        for (int v = 0; v < 16; v++) begin
            sq_t  = SW'(pk_cnt[v]);
            sumsq = sumsq + sq_t * sq_t;
        end
        runs_fail = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 6; k++)
                if (run_cnt[b][k] < CW'(run_min(k)) || run_cnt[b][k] > CW'(run_max(k)))
                    runs_fail = 1'b1;
        mono_fail  = !(ones_cnt > CW'(MONO_LO) && ones_cnt < CW'(MONO_HI));
        poker_fail = !((sumsq << 4) > SW'(POK_LO) && (sumsq << 4) < SW'(POK_HI));
    end

    assign eval_o    = eval_pend;
    assign busy      = eval_pend;
    assign last_half = !held && (idx == CW'(BLOCK_BITS - 32));
endmodule

// File: rtl/ent_hlth_top.sv
// Health tester top: register bus, test data injection, fail flags and live
// sampling. Assumes one bus write per cycle and BLOCK_BITS mod 64 == 32.
module ent_hlth_top
    import ent_hlth_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int BLOCK_BITS = 20000,
    localparam int CW = $clog2(BLOCK_BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [2*DW-1:0] noise_in
);
    logic          tmode, known, live, stall;
    logic [DW-1:0] raw_lo, raw_hi;
    logic          f_mono, f_poker, f_runs;
    logic          wr_ctrl, wr_test, wr_ack, wr_alarm, wr_lo, wr_hi;
    logic          en, en_nx, clr, test_ready, step_go, step_half;
    logic [2*DW-1:0] step_data;
    logic          ser_busy, bit_vld, bit_val;
    logic [CW-1:0] ones_cnt;
    logic [CW-1:0] pk_cnt [16];
    logic          eval, mono_fail, poker_fail, runs_fail, st_busy, held, last_half;

    assign wr_ctrl  = bus_wr && (bus_addr == RG_CTRL);
    assign wr_test  = bus_wr && (bus_addr == RG_TEST);
    assign wr_ack   = bus_wr && (bus_addr == RG_ACK);
    assign wr_alarm = bus_wr && (bus_addr == RG_ALARM);
    assign wr_lo    = bus_wr && (bus_addr == RG_RAWLO);
    assign wr_hi    = bus_wr && (bus_addr == RG_RAWHI);

    assign en    = tmode && known;
    assign en_nx = (wr_ctrl ? bus_wdata[B_TMODE] : tmode) && (wr_test ? bus_wdata[B_KNOWN] : known);
    assign clr   = (en_nx != en);

    assign test_ready = en && !ser_busy && !st_busy;
    assign step_go    = test_ready && ((wr_hi && !last_half) || (wr_lo && last_half));
    assign step_half  = wr_lo;
    assign step_data  = wr_lo ? {{DW{1'b0}}, bus_wdata} : {bus_wdata, raw_lo};

    // Hold the software-written mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmode <= 1'b0;
            known <= 1'b0;
            live  <= 1'b0;
            stall <= 1'b0;
        end else begin
            if (wr_ctrl) tmode <= bus_wdata[B_TMODE];
            if (wr_test) begin
                known <= bus_wdata[B_KNOWN];
                live  <= bus_wdata[B_LIVE];
            end
            if (wr_alarm) stall <= bus_wdata[B_STALL];
        end
    end

    // Raw data registers: live samples in sampling mode, else last write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_lo <= '0;
            raw_hi <= '0;
        end else if (live) begin
            raw_lo <= noise_in[DW-1:0];
            raw_hi <= noise_in[2*DW-1:DW];
        end else begin
            if (wr_lo) raw_lo <= bus_wdata;
            if (wr_hi) raw_hi <= bus_wdata;
        end
    end

    // Sticky fail flags: set at evaluation, cleared by acknowledge or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            f_mono  <= 1'b0;
            f_poker <= 1'b0;
            f_runs  <= 1'b0;
        end else begin
            f_mono  <= (f_mono  && !(wr_ack && bus_wdata[B_FMONO])) || (eval && mono_fail);
            f_poker <= (f_poker && !(wr_ack && bus_wdata[B_FPOK]))  || (eval && poker_fail);
            f_runs  <= (f_runs  && !(wr_ack && bus_wdata[B_FRUN]))  || (eval && runs_fail);
        end
    end

    ent_hlth_ser #(.DW(DW)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .start   (step_go),
        .half    (step_half),
        .data    (step_data),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .busy    (ser_busy)
    );

    ent_hlth_stats #(.BLOCK_BITS(BLOCK_BITS)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .stall      (stall),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .ones_cnt   (ones_cnt),
        .pk_cnt     (pk_cnt),
        .eval_o     (eval),
        .mono_fail  (mono_fail),
        .poker_fail (poker_fail),
        .runs_fail  (runs_fail),
        .busy       (st_busy),
        .held       (held),
        .last_half  (last_half)
    );

    // Read multiplexer for the register map.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RG_CTRL:  bus_rdata[B_TMODE] = tmode;
            RG_TEST: begin
                bus_rdata[B_KNOWN] = known;
                bus_rdata[B_LIVE]  = live;
            end
            RG_STAT: begin
                bus_rdata[B_READY] = test_ready;
                bus_rdata[B_FMONO] = f_mono;
                bus_rdata[B_FPOK]  = f_poker;
                bus_rdata[B_FRUN]  = f_runs;
            end
            RG_ALARM: bus_rdata[B_STALL] = stall;
            RG_RAWLO: bus_rdata = raw_lo;
            RG_RAWHI: bus_rdata = raw_hi;
            RG_ONES:  bus_rdata = DW'(ones_cnt);
            RG_PK0, RG_PK1, RG_PK2, RG_PK3: begin
                for (int b = 0; b < 4; b++)
                    bus_rdata[8*b +: 8] = pk_cnt[{bus_addr[1:0], 2'(b)}][7:0];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ent_hlth_chk.sv
// Protocol checker for the health tester, attached by bind. Assumes a
// driver that keeps the stall bit steady during block evaluation.
module ent_hlth_chk
    import ent_hlth_pkg::*;
#(
    parameter int CW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    bus_addr,
    input logic          bus_wr,
    input logic [31:0]   bus_wdata,
    input logic          test_ready,
    input logic          step_go,
    input logic          eval,
    input logic          f_mono,
    input logic          held,
    input logic          stall,
    input logic          clr,
    input logic [CW-1:0] ones_cnt
);
    assert_step_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_go |=> !test_ready);

    assert_known_off_drops_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_TEST && !bus_wdata[B_KNOWN]) |=> !test_ready);

    assert_ack_clears_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_ACK && bus_wdata[B_FMONO] && !eval) |=> !f_mono);

    assert_flag_only_at_block_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_mono) |-> $past(eval));

    assert_held_counts_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (held && stall && !clr) |=> $stable(ones_cnt));
endmodule

bind ent_hlth_top ent_hlth_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .test_ready (test_ready),
    .step_go    (step_go),
    .eval       (eval),
    .f_mono     (f_mono),
    .held       (held),
    .stall      (stall),
    .clr        (clr),
    .ones_cnt   (ones_cnt)
);

// File: tb/ent_hlth_top_bench.sv
// Bench: drives the tester like a software driver and compares every block
// against a reference model built from the requirements.
module ent_hlth_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] noise_in = '0;

    int nchk = 0;
    int nfail = 0;
    bit blk [BLK];
    int fill;
    int e_ones;
    int e_pk [16];
    bit e_fm, e_fp, e_fr;
    logic [31:0] rv;

    ent_hlth_top u_ent_hlth_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .noise_in  (noise_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 1000; i++) begin
            rd(4'd2, s);
            if (s[8]) return;
        end
        nchk++;
        nfail++;
        $display("FAIL R3 ready never returned actual=0 expected=1");
    endtask

    // One step as a driver would issue it; record the bits when counted.
    task automatic step(input logic [31:0] lo, input logic [31:0] hi, input bit half,
                        input bit rec, input bit probe);
        wr(4'd5, lo);
        if (!half) wr(4'd6, hi);
        if (probe) wr(4'd6, 32'hFFFF_FFFF);
        wait_ready();
        if (rec) begin
            for (int i = 0; i < 32; i++) blk[fill++] = lo[i];
            if (!half) for (int i = 0; i < 32; i++) blk[fill++] = hi[i];
        end
    endtask

    // Reference model of counts and verdicts for the recorded block.
    task automatic model();
        int runs [2][6];
        int len, k;
        longint sq;
        bit pb;
        e_ones = 0;
        for (int v = 0; v < 16; v++) e_pk[v] = 0;
        for (int b = 0; b < 2; b++) for (int j = 0; j < 6; j++) runs[b][j] = 0;
        len = 0;
        pb = 1'b0;
        for (int i = 0; i < BLK; i++) begin
            e_ones += int'(blk[i]);
            if (i % 4 == 3) e_pk[{blk[i], blk[i-1], blk[i-2], blk[i-3]}]++;
            if (i > 0 && blk[i] != pb) begin
                k = (len > 6) ? 6 : len;
                runs[pb][k-1]++;
                len = 0;
            end
            pb = blk[i];
            len++;
        end
        k = (len > 6) ? 6 : len;
        runs[pb][k-1]++;
        sq = 0;
        for (int v = 0; v < 16; v++) sq += longint'(e_pk[v]) * e_pk[v];
        e_fm = !(e_ones > 9654 && e_ones < 10346);
        e_fp = !(16 * sq > 64'd25005150 && 16 * sq < 64'd25287000);
        e_fr = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int j = 0; j < 6; j++)
                if (runs[b][j] < ent_hlth_pkg::run_min(j) || runs[b][j] > ent_hlth_pkg::run_max(j))
                    e_fr = 1'b1;
    endtask

    // kind 0: known pattern, 1: seeded random, 2: all ones.
    task automatic feed_block(input int kind);
        logic [31:0] lo, hi;
        fill = 0;
        for (int s = 0; s < 313; s++) begin
            case (kind)
                0: begin
                    lo = (s < 11) ? 32'h1111_1333 : 32'h0123_4567;
                    hi = (s < 11) ? 32'h3555_779F : 32'h89AB_CDEF;
                end
                1: begin
                    lo = $urandom;
                    hi = $urandom;
                end
                default: begin
                    lo = 32'hFFFF_FFFF;
                    hi = 32'hFFFF_FFFF;
                end
            endcase
            step(lo, hi, s == 312, 1'b1, kind == 1 && s == 100);
        end
        model();
    endtask

    function automatic logic [31:0] exp_stat(input bit m, input bit p, input bit r);
        return {23'd0, 1'b1, m, p, 1'b0, r, 4'd0};
    endfunction

    task automatic check_counts(input string tag);
        logic [31:0] v;
        rd(4'd7, v);
        chk({"R5 ones ", tag}, v, e_ones);
        for (int g = 0; g < 4; g++) begin
            rd(4'(8 + g), v);
            chk({"R6 poker ", tag}, v, {e_pk[4*g+3][7:0], e_pk[4*g+2][7:0],
                                        e_pk[4*g+1][7:0], e_pk[4*g][7:0]});
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(4'd2, rv); chk("R1 status after reset", rv, 32'h0);
        rd(4'd7, rv); chk("R1 ones after reset", rv, 32'h0);
        rd(4'd8, rv); chk("R1 poker after reset", rv, 32'h0);
        rd(4'd0, rv); chk("R1 control after reset", rv, 32'h0);

        wr(4'd0, 32'h100);
        rd(4'd2, rv); chk("R2 ready needs both bits", rv, 32'h0);
        wr(4'd1, 32'h20);
        rd(4'd2, rv); chk("R2 ready at enable", rv, 32'h100);

        wr(4'd4, 32'h8000);
        feed_block(0);
        rd(4'd2, rv); chk("R7 R8 R9 known pattern flags", rv, exp_stat(e_fm, e_fp, e_fr));
        check_counts("known");

        wr(4'd3, 32'h40);
        rd(4'd2, rv); chk("R10 poker ack", rv, exp_stat(e_fm, 1'b0, e_fr));

        step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        rd(4'd7, rv); chk("R11 held ones", rv, e_ones);

        wr(4'd1, 32'h0);
        rd(4'd2, rv); chk("R13 known off status", rv, 32'h0);
        rd(4'd7, rv); chk("R13 known off counters", rv, 32'h0);

        noise_in = 64'hC3A5_0F1E_9B72_6D48;
        wr(4'd1, 32'h2000);
        rd(4'd5, rv); chk("R14 live low", rv, 32'h9B72_6D48);
        rd(4'd6, rv); chk("R14 live high", rv, 32'hC3A5_0F1E);

        wr(4'd1, 32'h20);
        rd(4'd2, rv); chk("R2 ready after restart", rv, 32'h100);
        wr(4'd5, 32'h0000_1234);
        rd(4'd2, rv); chk("R4 lone low write starts no step", rv, 32'h100);

        feed_block(1);
        rd(4'd2, rv); chk("R7 R8 R9 random flags", rv, exp_stat(e_fm, e_fp, e_fr));
        check_counts("random");

        wr(4'd4, 32'h0);
        rd(4'd7, rv); chk("R11 stall release clears", rv, 32'h0);

        feed_block(2);
        rd(4'd2, rv); chk("R7 R8 R9 all ones flags", rv, exp_stat(e_fm, e_fp, e_fr));
        chk("R7 all ones model", {29'd0, e_fm, e_fp, e_fr}, 32'h7);
        rd(4'd7, rv); chk("R12 counters reset without stall", rv, 32'h0);

        wr(4'd3, 32'hD0);
        rd(4'd2, rv); chk("R10 all flags acked", rv, 32'h100);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule